// File: doc/BRIEF.md
# Speech Decoder Strobe and Data Regenerator

This block sits between a serial bit source with loose timing and a delta-modulation speech decoder. The source gives a data bit and a clock strobe whose edges may be too close together, and whose pulses may be very short, spiky or stretched. The block samples both lines on a fast system clock and sends the decoder a clean clock/data pair. Every rising strobe edge latches the bit. After a programmable setup delay, one output clock pulse of fixed width follows. The data stays put through that pulse and until the next capture.

A four-state machine runs each pulse. IDLE waits. It leaves for SETUP when an edge is detected or a queued edge is waiting. SETUP holds the clock low for `SETUP_CYC` cycles after the bit is loaded and then goes to HIGH. HIGH drives the clock for `HIGH_CYC` cycles and then goes to GAP. GAP holds the clock low for `GAP_CYC` cycles and then returns to IDLE. An edge that arrives outside IDLE goes into a one-entry holding slot. IDLE starts that held edge on the next cycle. If a further edge comes while the slot is full, it is dropped and a sticky flag is raised. At a 12 kHz bit rate the parameters are chosen so that the rising clock edge falls near mid-bit. The same settings still fit a 64 kHz rate, because one full sequence is much shorter than a bit.

Top module: `strobe_retimer`

## Requirements
- R1: Each detected rising edge of `strobe_in` produces exactly one `clk_out` pulse that is high for exactly `HIGH_CYC` system cycles. This holds whatever the strobe's own width, including a strobe high for only one system cycle.
- R2: The value of `bit_in` sampled together with the strobe edge is the value presented on `bit_out` for that pulse.
- R3: A strobe edge first seen high at system-clock edge k, when the machine is idle, loads `bit_out` at edge k+`SYNC_STAGES`. `clk_out` then rises exactly `SETUP_CYC` edges later.
- R4: `bit_out` has been unchanged for at least `SETUP_CYC` cycles when `clk_out` rises.
- R5: `bit_out` does not change while `clk_out` is high, nor in the cycle in which it falls.
- R6: An edge detected while a sequence runs and the slot is empty is held. Its pulse starts loading one cycle after the running sequence's GAP ends, that is `SETUP_CYC+HIGH_CYC+GAP_CYC+1` cycles after the previous load. Holding an edge does not set `overrun`.
- R7: An edge detected while the slot already holds an edge is discarded and gives no pulse. It sets `overrun`, which stays at 1 until reset. An edge in the very cycle the slot is emptied is held instead.
- R8: While `rst` is high, from the first clock edge, `clk_out`, `bit_out` and `overrun` are 0. Any pulse in progress or held edge is discarded.
- R9: Between two `clk_out` pulses the clock stays low for at least `SETUP_CYC+GAP_CYC+1` cycles. This bounds the duty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Raw serial data bit, asynchronous |
| strobe_in | input | 1 | Raw clock strobe, asynchronous; rising edge marks a bit |
| bit_out | output | 1 | Regenerated data bit to the decoder |
| clk_out | output | 1 | Regenerated clock pulse to the decoder |
| overrun | output | 1 | Sticky flag: a strobe edge was lost because the slot was full |

## Verification
The bench sends one-cycle runt strobes and very long strobes. A regenerator that follows the input width, instead of timing its own pulse, would give a short or stretched clock. It also sends edges that land in the last GAP cycle and in the exact cycle a held edge is taken. A design with an off-by-one in the busy test would either lose the held bit or present it twice. Bursts of three close edges show whether the middle bit survives while the third is dropped and flagged, and whether the flag stays set. A random stream, checked against a bench model of load times, catches any drift in latency or setup when edges and data values vary.

// File: rtl/retime_pkg.sv
package retime_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_GAP
    } rt_state_e;
endpackage

// File: rtl/sync_chain.sv
// Multi-stage synchroniser for a small bundle of asynchronous lines.
module sync_chain #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/edge_queue.sv
// One-entry holding slot for strobe edges that arrive during a pulse sequence.
module edge_queue (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic data_i,
    input  logic busy_i,
    input  logic take_i,
    output logic pend_o,
    output logic pdata_o,
    output logic ovr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o  <= 1'b0;
            pdata_o <= 1'b0;
            ovr_o   <= 1'b0;
        end else if (edge_i && busy_i) begin
            if (pend_o && !take_i) begin
                ovr_o <= 1'b1;
            end else begin
                pend_o  <= 1'b1;
                pdata_o <= data_i;
            end
        end else if (take_i) begin
            pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pulse_fsm.sv
// Sequencer: load bit, wait setup, drive fixed-width pulse, enforce low gap.
module pulse_fsm
    import retime_pkg::*;
#(
    parameter int SETUP_CYC = 6,
    parameter int HIGH_CYC  = 10,
    parameter int GAP_CYC   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic data_i,
    input  logic pend_i,
    input  logic pdata_i,
    output logic busy_o,
    output logic take_o,
    output logic clk_o,
    output logic dat_o
);
    localparam int MAXA = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
    localparam int MAXC = (MAXA > GAP_CYC) ? MAXA : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HI_LAST  = CW'(HIGH_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

    rt_state_e     st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          load, ld_val;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt + 1'b1;
        load   = 1'b0;
        ld_val = data_i;
        take_o = 1'b0;
        unique case (st)
            ST_IDLE: begin
                cnt_nx = '0;
                if (pend_i) begin
                    st_nx  = ST_SETUP;
                    load   = 1'b1;
                    ld_val = pdata_i;
                    take_o = 1'b1;
                end else if (edge_i) begin
                    st_nx = ST_SETUP;
                    load  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (cnt == SET_LAST) begin
                    st_nx  = ST_HIGH;
                    cnt_nx = '0;
                end
            end
            ST_HIGH: begin
                if (cnt == HI_LAST) begin
                    st_nx  = ST_GAP;
                    cnt_nx = '0;
                end
            end
            ST_GAP: begin
                if (cnt == GAP_LAST) begin
                    st_nx  = ST_IDLE;
                    cnt_nx = '0;
                end
            end
        endcase
    end

    assign busy_o = (st != ST_IDLE) || pend_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_o <= 1'b0;
            dat_o <= 1'b0;
        end else begin
            clk_o <= (st_nx == ST_HIGH);
            if (load) dat_o <= ld_val;
        end
    end
endmodule

// File: rtl/strobe_retimer.sv
module strobe_retimer #(
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 6,
    parameter int HIGH_CYC    = 10,
    parameter int GAP_CYC     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic strobe_in,
    output logic bit_out,
    output logic clk_out,
    output logic overrun
);
    logic [1:0] raw_lines, sync_lines;
    logic       strb_q, rise;
    logic       busy, take, pend, pdata;

    assign raw_lines = {strobe_in, bit_in};

    sync_chain #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    always_ff @(posedge clk) begin
        if (rst) strb_q <= 1'b0;
        else     strb_q <= sync_lines[1];
    end

    assign rise = sync_lines[1] & ~strb_q;

    edge_queue u_queue (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (rise),
        .data_i  (sync_lines[0]),
        .busy_i  (busy),
        .take_i  (take),
        .pend_o  (pend),
        .pdata_o (pdata),
        .ovr_o   (overrun)
    );

    pulse_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (rise),
        .data_i  (sync_lines[0]),
        .pend_i  (pend),
        .pdata_i (pdata),
        .busy_o  (busy),
        .take_o  (take),
        .clk_o   (clk_out),
        .dat_o   (bit_out)
    );
endmodule

// File: rtl/strobe_retimer_chk.sv
module strobe_retimer_chk #(
    parameter int SETUP_CYC = 6,
    parameter int HIGH_CYC  = 10,
    parameter int GAP_CYC   = 4
) (
    input logic clk,
    input logic rst,
    input logic clk_out,
    input logic bit_out,
    input logic overrun
);
    localparam int LO_MIN = SETUP_CYC + GAP_CYC + 1;
    localparam int TOP    = (LO_MIN > HIGH_CYC + 1) ? LO_MIN : HIGH_CYC + 1;
    localparam int W      = $clog2(TOP + 1) + 1;

    logic [W-1:0] hi_cnt, lo_cnt, since_chg;
    logic         b_prev, rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            hi_cnt    <= '0;
            lo_cnt    <= W'(LO_MIN);
            since_chg <= W'(SETUP_CYC);
            b_prev    <= 1'b0;
        end else begin
            b_prev <= bit_out;
            hi_cnt <= clk_out ? ((hi_cnt < W'(HIGH_CYC + 1)) ? hi_cnt + 1'b1 : hi_cnt) : '0;
            lo_cnt <= clk_out ? '0 : ((lo_cnt < W'(LO_MIN)) ? lo_cnt + 1'b1 : lo_cnt);
            if (bit_out != b_prev) since_chg <= '0;
            else if (since_chg < W'(SETUP_CYC)) since_chg <= since_chg + 1'b1;
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_out) |-> hi_cnt == W'(HIGH_CYC)); // R1

    AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
        hi_cnt <= W'(HIGH_CYC)); // R1

    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> since_chg >= W'(SETUP_CYC - 1)); // R4

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        clk_out |-> $stable(bit_out)); // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R7

    AST_LOW_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> lo_cnt >= W'(LO_MIN)); // R9

    always_ff @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_QUIET: assert (!clk_out && !bit_out && !overrun); // R8
        end
    end
endmodule

bind strobe_retimer strobe_retimer_chk #(
    .SETUP_CYC (SETUP_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .GAP_CYC   (GAP_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_out (clk_out),
    .bit_out (bit_out),
    .overrun (overrun)
);

// File: tb/strobe_retimer_bench.sv
module strobe_retimer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC  = 2;
    localparam int SETUP = 6;
    localparam int HIGH  = 10;
    localparam int GAP   = 4;
    localparam int SEQ   = SETUP + HIGH + GAP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic strobe_in = 1'b0;
    logic bit_out, clk_out, overrun;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    strobe_retimer #(
        .SYNC_STAGES (SYNC),
        .SETUP_CYC   (SETUP),
        .HIGH_CYC    (HIGH),
        .GAP_CYC     (GAP)
    ) u_strobe_retimer (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .strobe_in (strobe_in),
        .bit_out   (bit_out),
        .clk_out   (clk_out),
        .overrun   (overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // expected-value model
    int exp_load[$];
    int exp_dat[$];
    int last_load = -100000;
    bit exp_ovr = 1'b0;

    // observed pulses
    int rise_q[$];
    int rdat_q[$];
    int setup_q[$];
    int wid_q[$];
    int hold_bad = 0;
    int last_chg = -100000;
    int hw = 0;
    logic pc = 1'b0;
    logic pb = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            pc = 1'b0;
            pb = 1'b0;
            hw = 0;
            last_chg = -100000;
        end else begin
            if (bit_out !== pb) begin
                last_chg = cyc;
                if (clk_out || pc) hold_bad++;
            end
            if (clk_out && !pc) begin
                rise_q.push_back(cyc);
                rdat_q.push_back(int'(bit_out));
                setup_q.push_back(cyc - last_chg);
                hw = 0;
            end
            if (clk_out) hw++;
            if (!clk_out && pc) wid_q.push_back(hw);
            pc = clk_out;
            pb = bit_out;
        end
    end

    function automatic int next_load(int e, int prev);
        if (e >= prev + SEQ + 1) return e;
        if (e >= prev) return prev + SEQ + 1;
        return -1;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(string req, int act, int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        strobe_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 clk_out in reset", int'(clk_out), 0);
        chk("R8 bit_out in reset", int'(bit_out), 0);
        chk("R8 overrun in reset", int'(overrun), 0);
        rst = 1'b0;
        exp_load.delete(); exp_dat.delete();
        rise_q.delete(); rdat_q.delete(); setup_q.delete(); wid_q.delete();
        last_load = -100000;
        exp_ovr = 1'b0;
        hold_bad = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(bit d, int width, int gap);
        int e, l;
        @(negedge clk);
        bit_in = d;
        strobe_in = 1'b1;
        e = cyc + 1 + SYNC;
        l = next_load(e, last_load);
        if (l < 0) begin
            exp_ovr = 1'b1;
        end else begin
            exp_load.push_back(l);
            exp_dat.push_back(int'(d));
            last_load = l;
        end
        repeat (width) @(negedge clk);
        strobe_in = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic verify(string tag);
        int n;
        repeat (SEQ + 40) @(negedge clk);
        n = exp_load.size();
        chk({"R1 pulse count ", tag}, rise_q.size(), n);
        chk({"R1 width count ", tag}, wid_q.size(), n);
        for (int i = 0; i < n && i < rise_q.size(); i++) begin
            chk({"R3 rise cycle ", tag}, rise_q[i], exp_load[i] + SETUP);
            chk({"R2 data value ", tag}, rdat_q[i], exp_dat[i]);
            chk_ge({"R4 setup ", tag}, setup_q[i], SETUP);
            if (i < wid_q.size()) chk({"R1 width ", tag}, wid_q[i], HIGH);
            if (i > 0) chk_ge({"R9 low gap ", tag}, rise_q[i] - rise_q[i-1] - HIGH, SETUP + GAP + 1);
        end
        chk({"R5 hold violations ", tag}, hold_bad, 0);
        chk({"R7 overrun ", tag}, int'(overrun), int'(exp_ovr));
        exp_load.delete(); exp_dat.delete();
        rise_q.delete(); rdat_q.delete(); setup_q.delete(); wid_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        do_reset();

        // R1 R2 R3: one-cycle runt strobe
        send(1'b1, 1, 60);
        verify("runt");

        // R1: very long strobe yields a single pulse
        send(1'b0, 45, 60);
        verify("long");

        // R6: second edge mid-sequence is held, no overrun
        send(1'b1, 2, 5);
        send(1'b0, 2, 60);
        chk("R6 no overrun on single hold", int'(overrun), 0);
        verify("hold");

        // R6: edge landing in last GAP cycle (busy) is held
        send(1'b0, 1, SEQ - 1);
        send(1'b1, 1, 60);
        verify("gapedge");

        // R7: three quick edges, third dropped and flagged
        send(1'b1, 1, 3);
        send(1'b0, 1, 3);
        send(1'b1, 1, 3);
        verify("overrun");
        repeat (50) @(negedge clk);
        chk("R7 overrun sticky", int'(overrun), 1);

        // R8: reset mid-pulse clears everything
        send(1'b1, 1, SETUP + 4);
        send(1'b1, 1, 2);
        do_reset();
        repeat (SEQ + 20) @(negedge clk);
        chk("R8 no pulse after reset", rise_q.size(), 0);
        chk("R8 held edge discarded", int'(bit_out), 0);

        // random stream, bench model predicts loads and overrun
        for (int k = 0; k < 300; k++) begin
            send(1'($urandom_range(0, 1)), int'($urandom_range(1, 12)), int'($urandom_range(1, 40)));
            if (k % 50 == 49) verify("random");
        end
        verify("random tail");

        summary();
        $finish;
    end
endmodule